// File: doc/BRIEF.md
# LPC DMA Peripheral Data Engine

This block sits on the peripheral side of a 4-bit multiplexed LPC bus and carries out the data phase of a DMA cycle. It recognises the start nibble and the DMA cycle type. It keeps the transfer direction, then takes the channel number and the terminal-count flag from one nibble and the transfer size from the next. On a DMA read it collects each byte from the host as two nibbles and pushes the byte into a local byte sink. It then answers with a SYNC code. On a DMA write, and on a verify cycle, which has the same bus encoding, it drives a SYNC code and then two nibbles taken from the head of a local byte source.

The end of a transfer travels only in the SYNC code of each byte. The local side chooses between "more data" and "last byte", and can flag an error on the last byte. The block never signals the end by dropping a request line. Terminal count is held from the channel nibble and reported to the local side only when the final byte of the selected size has moved. After the last exchange the engine drives the bus high for one clock, releases it, and returns to idle.

Top module: `lpc_dma_engine`

## Requirements
- R1: While reset is applied and after it is released, lad_oe, wr_push, rd_pop and tc_out are all low.
- R2: A cycle begins when lframe_n is low and lad_in is 0000. If lframe_n stays low with 0000, the engine keeps waiting for the cycle-type nibble. In the first nibble with lframe_n high, bits 3:2 equal to 10 mark a DMA cycle and bit 1 gives the direction: 0 means host to peripheral (read) and 1 means peripheral to host (write or verify). Any other cycle type is ignored and the engine never drives the bus for it.
- R3: In the channel nibble, bits 2:0 must equal the CHAN_ID parameter, otherwise the cycle is ignored. Bit 3 of the same nibble is the terminal-count flag.
- R4: In the size nibble, bits 1:0 equal to 01 select a two-byte transfer. Any other value selects one byte.
- R5: Each read byte takes these clocks in order: low nibble from the host, high nibble from the host, two host turnaround clocks, one SYNC clock driven by the engine, and two engine turnaround clocks (1111, then released). wr_push is high for one clock, the clock after the high nibble, with the assembled byte on wr_data.
- R6: A write has two host turnaround clocks first. Then each byte takes one SYNC clock, rd_data[3:0] and then rd_data[7:4]. rd_pop is high in the clock that drives the high nibble. After the last byte the engine drives 1111 for one clock and then releases the bus.
- R7: Each SYNC clock drives 1001 when end_req is low, 0000 when end_req is high and err_req is low, and 1010 when both are high.
- R8: tc_out is high for one clock, the clock after the final byte of the selected size completes, and only when the terminal-count flag was set. It stays low in all other clocks.
- R9: After its final turnaround the engine returns to idle and accepts the next cycle, including one that follows an ignored cycle.
- R10: lad_oe is low in every clock where the host owns the bus: the header nibbles, host data nibbles, host turnaround, and the released second turnaround clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Nibble bus as seen at the pins |
| lad_out | output | 4 | Nibble the engine drives |
| lad_oe | output | 1 | Output enable for lad_out |
| end_req | input | 1 | Local side marks the current byte as the last one |
| err_req | input | 1 | Replaces the last-byte code with the error code |
| rd_data | input | 8 | Head byte of the local source (write direction) |
| rd_pop | output | 1 | Source head consumed this clock |
| wr_data | output | 8 | Byte received from the host (read direction) |
| wr_push | output | 1 | wr_data valid this clock |
| tc_out | output | 1 | Terminal count reached with the final byte |

## Verification
On every cycle the assertions check these rules: a SYNC clock only carries one of the three legal codes; the engine's turnaround is always followed by a released bus; rd_pop only occurs while the engine drives; push and terminal-count pulses are single clocks; and the byte counter never passes the selected size. Only the bench's scenarios can show the rest: the exact clock in which each field appears, the nibble order and byte values, the SYNC code chosen for each mix of end and error inputs, terminal count landing on the second byte of a two-byte transfer, and silence on foreign channels and cycle types. The bench sweeps both directions, all four size codes, both terminal-count settings and all three SYNC outcomes.

// File: rtl/lpc_dma_pkg.sv
package lpc_dma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CYC,
    ST_CHAN,
    ST_SIZE,
    ST_RLO,
    ST_RHI,
    ST_HTA0,
    ST_HTA1,
    ST_SYNC,
    ST_WLO,
    ST_WHI,
    ST_PTA0,
    ST_PTA1
  } seq_st_e;

  typedef struct packed {
    logic wr;   // 1: peripheral to host
    logic tc;   // terminal count held from channel nibble
    logic two;  // two-byte transfer
  } hdr_t;

  localparam logic [3:0] NIB_START     = 4'h0;
  localparam logic [3:0] NIB_HIGH      = 4'hF;
  localparam logic [3:0] SYNC_MORE     = 4'h9;
  localparam logic [3:0] SYNC_LAST     = 4'h0;
  localparam logic [3:0] SYNC_LAST_ERR = 4'hA;
  localparam logic [1:0] CYC_DMA       = 2'b10;
  localparam logic [1:0] SIZE_TWO      = 2'b01;

endpackage

// File: rtl/lpc_dma_hdr.sv
module lpc_dma_hdr
  import lpc_dma_pkg::*;
#(
  parameter int unsigned CH_W = 3,
  parameter logic [CH_W-1:0] CHAN_ID = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lad_in,
  input  logic       cap_cyc,
  input  logic       cap_chan,
  input  logic       cap_size,
  output hdr_t       hdr,
  output logic       chan_ok
);

  hdr_t hdr_q, hdr_d;

  assign chan_ok = (lad_in[CH_W-1:0] == CHAN_ID);

  always_comb begin
    hdr_d = hdr_q;
    if (cap_cyc)  hdr_d.wr  = lad_in[1];
    if (cap_chan) hdr_d.tc  = lad_in[3];
    if (cap_size) hdr_d.two = (lad_in[1:0] == SIZE_TWO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else if (cap_cyc || cap_chan || cap_size) hdr_q <= hdr_d;
  end

  assign hdr = hdr_q;

endmodule

// File: rtl/lpc_dma_seq.sv
module lpc_dma_seq
  import lpc_dma_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 2,
  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lframe_n,
  input  logic [3:0] lad_in,
  input  hdr_t       hdr,
  input  logic       chan_ok,
  output seq_st_e    state,
  output logic       cap_cyc,
  output logic       cap_chan,
  output logic       cap_size,
  output logic [7:0] wr_data,
  output logic       wr_push,
  output logic       rd_pop,
  output logic       tc_out
);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d, nb;
  logic [3:0]       lo_q, lo_d;
  logic [7:0]       data_q, data_d;
  logic             push_q, push_d, tc_q, tc_d, last_byte;

  assign nb        = hdr.two ? CNT_W'(2) : CNT_W'(1);
  assign last_byte = (idx_q == nb - CNT_W'(1));
  assign cap_cyc   = (st_q == ST_CYC) && lframe_n;
  assign cap_chan  = (st_q == ST_CHAN);
  assign cap_size  = (st_q == ST_SIZE);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    lo_d   = lo_q;
    data_d = data_q;
    push_d = 1'b0;
    tc_d   = 1'b0;
    case (st_q)
      ST_IDLE: if (!lframe_n && lad_in == NIB_START) st_d = ST_CYC;
      ST_CYC: begin
        if (!lframe_n)                   st_d = (lad_in == NIB_START) ? ST_CYC : ST_IDLE;
        else if (lad_in[3:2] == CYC_DMA) st_d = ST_CHAN;
        else                             st_d = ST_IDLE;
      end
      ST_CHAN: st_d = chan_ok ? ST_SIZE : ST_IDLE;
      ST_SIZE: begin
        idx_d = '0;
        st_d  = hdr.wr ? ST_HTA0 : ST_RLO;
      end
      ST_RLO: begin
        lo_d = lad_in;
        st_d = ST_RHI;
      end
      ST_RHI: begin
        data_d = {lad_in, lo_q};
        push_d = 1'b1;
        tc_d   = hdr.tc && last_byte;
        st_d   = ST_HTA0;
      end
      ST_HTA0: st_d = ST_HTA1;
      ST_HTA1: st_d = ST_SYNC;
      ST_SYNC: begin
        if (hdr.wr) st_d = ST_WLO;
        else begin
          idx_d = idx_q + CNT_W'(1);
          st_d  = ST_PTA0;
        end
      end
      ST_WLO: st_d = ST_WHI;
      ST_WHI: begin
        tc_d  = hdr.tc && last_byte;
        idx_d = idx_q + CNT_W'(1);
        st_d  = last_byte ? ST_PTA0 : ST_SYNC;
      end
      ST_PTA0: st_d = ST_PTA1;
      ST_PTA1: st_d = (idx_q < nb) ? ST_RLO : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lo_q   <= '0;
      data_q <= '0;
      push_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      push_q <= push_d;
      tc_q   <= tc_d;
      if (st_q == ST_RLO) lo_q   <= lo_d;
      if (push_d)         data_q <= data_d;
    end
  end

  assign state   = st_q;
  assign wr_data = data_q;
  assign wr_push = push_q;
  assign tc_out  = tc_q;
  assign rd_pop  = (st_q == ST_WHI);

  // R5: one push per byte
  a_r5_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push |=> !wr_push);
  // R8: terminal count only when the held flag was set
  a_r8_tc_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> $past(hdr.tc));
  // R8: terminal count is a single clock
  a_r8_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |=> !tc_out);
  // R4: byte counter never passes the selected size
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= nb);

endmodule

// File: rtl/lpc_dma_drv.sv
module lpc_dma_drv
  import lpc_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_st_e    state,
  input  logic [7:0] rd_data,
  input  logic       end_req,
  input  logic       err_req,
  output logic [3:0] lad_out,
  output logic       lad_oe
);

  logic [3:0] sync_code;

  always_comb begin
    if (!end_req)     sync_code = SYNC_MORE;
    else if (err_req) sync_code = SYNC_LAST_ERR;
    else              sync_code = SYNC_LAST;
  end

  always_comb begin
    lad_oe  = 1'b1;
    lad_out = NIB_HIGH;
    case (state)
      ST_SYNC: lad_out = sync_code;
      ST_WLO:  lad_out = rd_data[3:0];
      ST_WHI:  lad_out = rd_data[7:4];
      ST_PTA0: lad_out = NIB_HIGH;
      default: lad_oe  = 1'b0;
    endcase
  end

  // R7: a SYNC clock carries only a legal code
  a_r7_sync_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC) |-> (lad_oe && (lad_out == SYNC_MORE || lad_out == SYNC_LAST ||
                                       lad_out == SYNC_LAST_ERR)));
  // R6: the engine releases the bus after driving high
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PTA0) |=> !lad_oe);

endmodule

// File: rtl/lpc_dma_engine.sv
module lpc_dma_engine
  import lpc_dma_pkg::*;
#(
  parameter int unsigned CH_W = 3,
  parameter logic [CH_W-1:0] CHAN_ID = 3'd5,
  parameter int unsigned MAX_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lframe_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  input  logic       end_req,
  input  logic       err_req,
  input  logic [7:0] rd_data,
  output logic       rd_pop,
  output logic [7:0] wr_data,
  output logic       wr_push,
  output logic       tc_out
);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  hdr_t       hdr;
  logic       chan_ok, cap_cyc, cap_chan, cap_size;
  seq_st_e    state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  lpc_dma_hdr #(.CH_W(CH_W), .CHAN_ID(CHAN_ID)) u_hdr (
    .clk(clk), .rst_n(rst_i), .lad_in(lad_in),
    .cap_cyc(cap_cyc), .cap_chan(cap_chan), .cap_size(cap_size),
    .hdr(hdr), .chan_ok(chan_ok)
  );

  lpc_dma_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_i), .lframe_n(lframe_n), .lad_in(lad_in),
    .hdr(hdr), .chan_ok(chan_ok), .state(state),
    .cap_cyc(cap_cyc), .cap_chan(cap_chan), .cap_size(cap_size),
    .wr_data(wr_data), .wr_push(wr_push), .rd_pop(rd_pop), .tc_out(tc_out)
  );

  lpc_dma_drv u_drv (
    .clk(clk), .rst_n(rst_i), .state(state), .rd_data(rd_data),
    .end_req(end_req), .err_req(err_req), .lad_out(lad_out), .lad_oe(lad_oe)
  );

  // R6: a source byte is consumed only while the engine drives it
  a_r6_pop_driving: assert property (@(posedge clk) disable iff (!rst_i)
    rd_pop |-> lad_oe);
  // R5: a push never happens in the write direction
  a_r5_push_read_only: assert property (@(posedge clk) disable iff (!rst_i)
    wr_push |-> !hdr.wr);
  // R10: host-owned fields are never driven
  a_r10_host_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_CYC || state == ST_CHAN || state == ST_SIZE || state == ST_RLO ||
     state == ST_RHI || state == ST_HTA0 || state == ST_HTA1) |-> !lad_oe);

endmodule

// File: tb/test_lpc_dma_engine.sv
`timescale 1ns/1ps
module test_lpc_dma_engine;

  localparam logic [2:0] MY_CH = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n, lframe_n, end_req, err_req;
  logic [3:0] lad_in, lad_out;
  logic       lad_oe, rd_pop, wr_push, tc_out;
  logic [7:0] rd_data, wr_data, fptr;
  int         checks = 0, errs = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  lpc_dma_engine #(.CHAN_ID(MY_CH)) i_lpc_dma_engine (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .end_req(end_req), .err_req(err_req),
    .rd_data(rd_data), .rd_pop(rd_pop), .wr_data(wr_data), .wr_push(wr_push),
    .tc_out(tc_out)
  );

  function automatic logic [7:0] src_byte(input logic [7:0] p);
    return p * 8'd29 + 8'h17;
  endfunction

  assign rd_data = src_byte(fptr);
  always @(posedge clk) if (rst_n && rd_pop) fptr <= fptr + 8'd1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] nib, input logic lf);
    lad_in = nib; lframe_n = lf;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [3:0] exp_sync(input logic e, input logic r);
    return !e ? 4'h9 : (r ? 4'hA : 4'h0);
  endfunction

  // full DMA cycle from the host side
  task automatic dma_cycle(input logic wr, input logic [1:0] size, input logic tc,
                           input logic e, input logic r, input int nstart, input int seed);
    int nb;
    logic [7:0] b, p0;
    nb = (size == 2'b01) ? 2 : 1;
    end_req = e; err_req = r;
    for (int s = 0; s < nstart; s++) step(4'h0, 1'b0);
    step({2'b10, wr, 1'b0}, 1'b1);
    chk("R10 quiet in channel", lad_oe, 0);
    step({tc, MY_CH}, 1'b1);
    chk("R10 quiet in size", lad_oe, 0);
    step({2'b00, size}, 1'b1);
    if (!wr) begin
      for (int k = 0; k < nb; k++) begin
        b = 8'h3C ^ 8'(seed * 7 + k * 81);
        chk("R10 quiet host data", lad_oe, 0);
        step(b[3:0], 1'b1);
        step(b[7:4], 1'b1);
        chk("R5 push", wr_push, 1);
        chk("R5 data", wr_data, b);
        chk("R8 tc read", tc_out, (tc && k == nb - 1));
        step(4'hF, 1'b1);
        chk("R5 push single", wr_push, 0);
        chk("R10 quiet host tar", lad_oe, 0);
        step(4'hF, 1'b1);
        chk("R5 sync drive", lad_oe, 1);
        chk("R7 sync code read", lad_out, exp_sync(e, r));
        step(4'hF, 1'b1);
        chk("R5 tar high", {lad_oe, lad_out}, 5'h1F);
        step(4'hF, 1'b1);
        chk("R10 tar released", lad_oe, 0);
        step(4'hF, 1'b1);
      end
    end else begin
      p0 = fptr;
      chk("R10 quiet host tar w", lad_oe, 0);
      step(4'hF, 1'b1);
      chk("R10 quiet host tar w2", lad_oe, 0);
      step(4'hF, 1'b1);
      for (int k = 0; k < nb; k++) begin
        b = src_byte(p0 + 8'(k));
        chk("R6 sync drive", lad_oe, 1);
        chk("R7 sync code write", lad_out, exp_sync(e, r));
        step(4'hF, 1'b1);
        chk("R6 low nibble", {lad_oe, lad_out}, {1'b1, b[3:0]});
        chk("R6 no early pop", rd_pop, 0);
        step(4'hF, 1'b1);
        chk("R6 high nibble", {lad_oe, lad_out}, {1'b1, b[7:4]});
        chk("R6 pop", rd_pop, 1);
        step(4'hF, 1'b1);
        chk("R8 tc write", tc_out, (tc && k == nb - 1));
      end
      chk("R6 final tar high", {lad_oe, lad_out}, 5'h1F);
      step(4'hF, 1'b1);
      chk("R6 tar released", lad_oe, 0);
      chk("R6 bytes consumed", fptr, p0 + 8'(nb));
      step(4'hF, 1'b1);
    end
    chk("R9 idle after cycle", {lad_oe, wr_push, rd_pop, tc_out}, 0);
  endtask

  // a header the engine must not answer, followed by bus traffic
  task automatic foreign(input logic [3:0] cyc, input logic [2:0] ch, input string req);
    step(4'h0, 1'b0);
    step(cyc, 1'b1);
    step({1'b1, ch}, 1'b1);
    for (int i = 0; i < 14; i++) begin
      step(4'(i), 1'b1);
      chk(req, {lad_oe, wr_push, rd_pop, tc_out}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    rst_n = 1'b0; lframe_n = 1'b1; lad_in = 4'hF; end_req = 1'b0; err_req = 1'b0;
    fptr = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {lad_oe, wr_push, rd_pop, tc_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {lad_oe, wr_push, rd_pop, tc_out}, 0);

    seed = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int sz = 0; sz < 4; sz++)
        for (int tc = 0; tc < 2; tc++)
          for (int sc = 0; sc < 3; sc++) begin
            dma_cycle(wr[0], sz[1:0], tc[0], sc != 0, sc == 2, 1 + (seed % 2), seed);
            seed++;
          end

    foreign(4'b0000, MY_CH, "R2 non-DMA ignored");
    dma_cycle(1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1, 99);
    foreign(4'b1000, MY_CH ^ 3'd1, "R3 other channel ignored");
    dma_cycle(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 3, 100);
    foreign(4'b1010, MY_CH ^ 3'd4, "R3 other channel write ignored");
    dma_cycle(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1, 101);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule